// File: doc/BRIEF.md
# SPI Timing Parameter Calculator

This block is a sequential helper for an SPI master. Software or a controller hands it a requested serial-clock period and three requested delays, all counted in input-clock cycles. The delays are chip-select-to-first-edge (lead), last-edge-to-chip-select-release (trail) and idle time between frames (gap). It also gives a start pulse. The block then finds the power-of-two prescaler that lets every 8-bit timing field of the master hold its value. It returns the exponent together with the four field values.

Every field means "count times 2^exponent input cycles". The exponent is chosen from the single largest requirement, and the search tries exponents in ascending order, one per clock. Delays are rounded up, so the real delay is never shorter than asked. The clock divider is also rounded up, so the real SCK frequency is never above the requested one. When no exponent fits, the block raises an error and reports all-zero fields. It never reports a clamped value.

Top module: `spi_timing_calc`

## Requirements
- R1: After reset, busy, done and error are 0, and prescale_exp and the four field outputs are 0.
- R2: A start sampled while idle captures the four requests and raises busy on the next cycle. The search tests exponent e in the e-th cycle after the accepting edge. done (or error) therefore rises e+1 clock edges after the edge that sampled start, and busy falls on the same edge.
- R3: prescale_exp is the smallest e in 0..7 with ceil(M / 2^e) <= 255. Here M is the largest of the four requests, and a requested divider of 0 counts as 1. Example: M = 6600 gives e = 5.
- R4: Each delay output (lead_cnt, trail_cnt, gap_cnt) equals ceil(request / 2^e), the smallest count whose duration is at least the request. A request of 0 gives 0.
- R5: sck_div equals ceil(max(req_sck_div,1) / 2^e). The resulting period is at least the requested one, which gives the fastest rate at or below the requested frequency. sck_div is never 0 while done is high.
- R6: When M > 255*128, error rises 8 edges after the accepting edge. done stays 0, and prescale_exp and all fields are 0.
- R7: done, error, prescale_exp and the fields hold their values from completion until the next accepted start. That start clears all of them on the accepting edge.
- R8: A start while busy is ignored: the running search and its result are unaffected.
- R9: done and error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| req_sck_div | input | REQ_W | Requested SCK period in input cycles |
| req_lead | input | REQ_W | Requested chip-select-to-first-edge delay |
| req_trail | input | REQ_W | Requested last-edge-to-release delay |
| req_gap | input | REQ_W | Requested delay between frames |
| busy | output | 1 | Search in progress |
| done | output | 1 | Valid result present |
| error | output | 1 | No exponent fits |
| prescale_exp | output | EXP_W | Chosen prescaler exponent |
| sck_div | output | FIELD_W | SCK divider field |
| lead_cnt | output | FIELD_W | Lead delay field |
| trail_cnt | output | FIELD_W | Trail delay field |
| gap_cnt | output | FIELD_W | Gap delay field |

## Verification
The bench aims at the edges of the fit test: a peak of exactly 255 and of 256, of exactly 32640 and of 32641, and the 6600-cycle case that must land on exponent 5. A design that compared with < instead of <= would pick one exponent too many at these points. A design that truncated instead of rounding up would return delays one count short and a clock that is too fast. The bench also sends a requested divider of 0, which a careless design turns into a zero SCK field. It pulses start during a search, where a design that restarts would shift the completion cycle. It leaves results idle for many cycles, where a design that keeps recomputing would let the fields drift.

// File: rtl/spi_tc_pkg.sv
package spi_tc_pkg;

  typedef enum logic {ST_IDLE, ST_SEARCH} calc_state_t;

  // Round-up division by a power of two: (v + 2^e - 1) >> e.
  // Operands are kept to 32 bits; request widths stay at or below 31 bits.
  function automatic logic [31:0] ceil_pow2(input logic [31:0] v, input logic [4:0] e);
    logic [31:0] bias;
    bias = (32'd1 << e) - 32'd1;
    return (v + bias) >> e;
  endfunction

  function automatic logic [31:0] max2(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_tc_peak.sv
module spi_tc_peak #(
  parameter int N = 4,
  parameter int W = 24
) (
  input  logic [N-1:0][W-1:0] vals,
  output logic [W-1:0]        peak
);
  import spi_tc_pkg::*;

  logic [W-1:0] run [N];

  assign run[0] = vals[0];
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign run[i] = W'(max2(32'(run[i-1]), 32'(vals[i])));
  end

  assign peak = run[N-1];

endmodule

// File: rtl/spi_tc_scale.sv
module spi_tc_scale #(
  parameter int REQ_W   = 24,
  parameter int FIELD_W = 8,
  parameter int EXP_W   = 3
) (
  input  logic [REQ_W-1:0]   req,
  input  logic [EXP_W-1:0]   exp_sel,
  output logic [FIELD_W-1:0] count,
  output logic               fits
);
  import spi_tc_pkg::*;

  localparam logic [31:0] LIMIT = 32'((1 << FIELD_W) - 1);

  logic [31:0] scaled;

  assign scaled = ceil_pow2(32'(req), 5'(exp_sel));
  assign fits   = (scaled <= LIMIT);
  assign count  = FIELD_W'(scaled);

endmodule

// File: rtl/spi_timing_calc.sv
module spi_timing_calc #(
  parameter int REQ_W   = 24,
  parameter int FIELD_W = 8,
  parameter int EXP_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [REQ_W-1:0]   req_sck_div,
  input  logic [REQ_W-1:0]   req_lead,
  input  logic [REQ_W-1:0]   req_trail,
  input  logic [REQ_W-1:0]   req_gap,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [EXP_W-1:0]   prescale_exp,
  output logic [FIELD_W-1:0] sck_div,
  output logic [FIELD_W-1:0] lead_cnt,
  output logic [FIELD_W-1:0] trail_cnt,
  output logic [FIELD_W-1:0] gap_cnt
);
  import spi_tc_pkg::*;

  localparam int NF = 4;  // 0 sck, 1 lead, 2 trail, 3 gap
  localparam logic [EXP_W-1:0] MAX_EXP = '1;

  calc_state_t state_q;
  logic [EXP_W-1:0]            search_exp_q;
  logic [NF-1:0][REQ_W-1:0]    req_q;
  logic [REQ_W-1:0]            peak;
  logic                        peak_fits;
  logic [FIELD_W-1:0]          peak_cnt;
  logic [FIELD_W-1:0]          cnt  [NF];
  logic [NF-1:0]               fit;
  logic [FIELD_W-1:0]          field_q [NF];
  logic [REQ_W-1:0]            sck_floor;

  // Named internal events
  logic ev_accept, ev_found, ev_exhausted;

  assign sck_floor    = (req_sck_div == '0) ? REQ_W'(1) : req_sck_div;
  assign busy         = (state_q == ST_SEARCH);
  assign ev_accept    = start && !busy;
  assign ev_found     = busy && peak_fits;
  assign ev_exhausted = busy && !peak_fits && (search_exp_q == MAX_EXP);

  spi_tc_peak #(.N(NF), .W(REQ_W)) u_peak (
    .vals (req_q),
    .peak (peak)
  );

  spi_tc_scale #(.REQ_W(REQ_W), .FIELD_W(FIELD_W), .EXP_W(EXP_W)) u_peak_fit (
    .req     (peak),
    .exp_sel (search_exp_q),
    .count   (peak_cnt),
    .fits    (peak_fits)
  );

  for (genvar i = 0; i < NF; i++) begin : g_field
    spi_tc_scale #(.REQ_W(REQ_W), .FIELD_W(FIELD_W), .EXP_W(EXP_W)) u_scale (
      .req     (req_q[i]),
      .exp_sel (search_exp_q),
      .count   (cnt[i]),
      .fits    (fit[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      search_exp_q <= '0;
      req_q        <= '0;
      done         <= 1'b0;
      error        <= 1'b0;
      prescale_exp <= '0;
      for (int i = 0; i < NF; i++) field_q[i] <= '0;
    end else if (ev_accept) begin
      state_q      <= ST_SEARCH;
      search_exp_q <= '0;
      req_q        <= {req_gap, req_trail, req_lead, sck_floor};
      done         <= 1'b0;
      error        <= 1'b0;
      prescale_exp <= '0;
      for (int i = 0; i < NF; i++) field_q[i] <= '0;
    end else if (ev_found) begin
      state_q      <= ST_IDLE;
      done         <= 1'b1;
      prescale_exp <= search_exp_q;
      for (int i = 0; i < NF; i++) field_q[i] <= cnt[i];
    end else if (ev_exhausted) begin
      state_q <= ST_IDLE;
      error   <= 1'b1;
    end else if (busy) begin
      search_exp_q <= search_exp_q + 1'b1;
    end
  end

  assign sck_div   = field_q[0];
  assign lead_cnt  = field_q[1];
  assign trail_cnt = field_q[2];
  assign gap_cnt   = field_q[3];

  // Assertions
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R9

  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (peak_fits == (&fit)) && (!peak_fits || peak_cnt >= cnt[0])); // R3

  AST_SEARCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ev_found && !ev_exhausted |=> busy && (search_exp_q == $past(search_exp_q) + 1'b1)); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) && !start |=> $stable({done, error, prescale_exp, sck_div, lead_cnt, trail_cnt, gap_cnt})); // R7

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (prescale_exp == '0) && (sck_div == '0) && (lead_cnt == '0) && (trail_cnt == '0) && (gap_cnt == '0)); // R6

  AST_SCK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sck_div != '0); // R5

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(req_q)); // R8

endmodule

// File: tb/sim_spi_timing_calc.sv
module sim_spi_timing_calc;
  localparam int REQ_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [REQ_W-1:0] req_sck_div = '0, req_lead = '0, req_trail = '0, req_gap = '0;
  logic busy, done, error;
  logic [2:0] prescale_exp;
  logic [7:0] sck_div, lead_cnt, trail_cnt, gap_cnt;

  int total = 0;
  int fails = 0;
  bit armed = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spi_timing_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_sck_div(req_sck_div), .req_lead(req_lead), .req_trail(req_trail), .req_gap(req_gap),
    .busy(busy), .done(done), .error(error), .prescale_exp(prescale_exp),
    .sck_div(sck_div), .lead_cnt(lead_cnt), .trail_cnt(trail_cnt), .gap_cnt(gap_cnt)
  );

  // Reference model state
  int m_busy = 0, m_done = 0, m_err = 0, m_left = 0;
  int m_exp = 0, m_sck = 0, m_lead = 0, m_trail = 0, m_gap = 0;
  int p_exp, p_sck, p_lead, p_trail, p_gap, p_err, p_lat;

  function automatic int up_div(int v, int d);
    return (v + d - 1) / d;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_left = 0;
      m_exp = 0; m_sck = 0; m_lead = 0; m_trail = 0; m_gap = 0;
    end else if (m_busy == 0 && start) begin
      int d, pk, dv;
      dv = (req_sck_div == 0) ? 1 : int'(req_sck_div);
      pk = dv;
      if (int'(req_lead) > pk) pk = int'(req_lead);
      if (int'(req_trail) > pk) pk = int'(req_trail);
      if (int'(req_gap) > pk) pk = int'(req_gap);
      p_err = 1; p_exp = 0; p_lat = 8;
      for (int e = 7; e >= 0; e--) begin
        d = 1 << e;
        if (up_div(pk, d) <= 255) begin p_err = 0; p_exp = e; end
      end
      if (p_err == 0) begin
        d = 1 << p_exp;
        p_lat = p_exp + 1;
        p_sck = up_div(dv, d); p_lead = up_div(int'(req_lead), d);
        p_trail = up_div(int'(req_trail), d); p_gap = up_div(int'(req_gap), d);
      end else begin
        p_exp = 0; p_sck = 0; p_lead = 0; p_trail = 0; p_gap = 0;
      end
      m_busy = 1; m_left = p_lat; m_done = 0; m_err = 0;
      m_exp = 0; m_sck = 0; m_lead = 0; m_trail = 0; m_gap = 0;
    end else if (m_busy != 0) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0;
        m_done = !p_err; m_err = p_err;
        m_exp = p_exp; m_sck = p_sck; m_lead = p_lead; m_trail = p_trail; m_gap = p_gap;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (armed && rst_n) begin
      chk(int'(busy) == m_busy, "R2", "busy", int'(busy), m_busy);
      chk(int'(done) == m_done, "R7", "done", int'(done), m_done);
      chk(int'(error) == m_err, "R6", "error", int'(error), m_err);
      chk(int'(prescale_exp) == m_exp, "R3", "prescale_exp", int'(prescale_exp), m_exp);
      chk(int'(sck_div) == m_sck, "R5", "sck_div", int'(sck_div), m_sck);
      chk(int'(lead_cnt) == m_lead, "R4", "lead_cnt", int'(lead_cnt), m_lead);
      chk(int'(trail_cnt) == m_trail, "R4", "trail_cnt", int'(trail_cnt), m_trail);
      chk(int'(gap_cnt) == m_gap, "R4", "gap_cnt", int'(gap_cnt), m_gap);
      chk(!(done && error), "R9", "done&error", int'(done && error), 0);
    end
  end

  task automatic kick(int dv, int ld, int tr, int gp);
    @(negedge clk);
    req_sck_div = REQ_W'(dv); req_lead = REQ_W'(ld); req_trail = REQ_W'(tr); req_gap = REQ_W'(gp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(int dv, int ld, int tr, int gp);
    kick(dv, ld, tr, gp);
    repeat (12) @(negedge clk);
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && error == 0, "R1", "flags after reset", int'({busy, done, error}), 0);
    chk({prescale_exp, sck_div, lead_cnt, trail_cnt, gap_cnt} == '0, "R1", "fields after reset",
        int'(sck_div), 0);
    rst_n = 1'b1;
    armed = 1'b1;
    @(negedge clk);

    run(12, 6600, 1320, 3432);            // R3 example: peak 6600 -> exponent 5
    chk(prescale_exp == 3'd5, "R3", "exp for 6600", int'(prescale_exp), 5);
    chk(lead_cnt == 8'd207, "R4", "lead ceil 6600/32", int'(lead_cnt), 207);
    chk(sck_div == 8'd1, "R5", "sck ceil 12/32", int'(sck_div), 1);

    run(0, 0, 0, 0);                      // R5: zero divider floors to 1
    chk(sck_div == 8'd1 && prescale_exp == 0, "R5", "zero divider", int'(sck_div), 1);
    run(255, 3, 17, 200);                 // R3: exactly fits at e=0
    chk(prescale_exp == 3'd0, "R3", "peak 255", int'(prescale_exp), 0);
    run(10, 256, 5, 9);                   // R3: one over -> e=1
    chk(prescale_exp == 3'd1 && sck_div == 8'd5, "R3", "peak 256", int'(prescale_exp), 1);
    run(7, 32640, 1, 129);                // R3: largest fitting peak -> e=7
    chk(prescale_exp == 3'd7 && lead_cnt == 8'd255, "R3", "peak 32640", int'(lead_cnt), 255);
    chk(gap_cnt == 8'd2 && trail_cnt == 8'd1, "R4", "round up at e=7", int'(gap_cnt), 2);
    run(7, 5, 32641, 9);                  // R6: infeasible
    chk(error == 1 && done == 0, "R6", "infeasible flags", int'(error), 1);

    // R7: hold for a long idle period, then a new start clears
    repeat (30) @(negedge clk);
    chk(error == 1, "R7", "error held", int'(error), 1);
    kick(40000, 1, 1, 1);
    chk(error == 0 && busy == 1, "R7", "start clears error", int'(error), 0);
    repeat (12) @(negedge clk);

    // R8: start during a search is ignored
    kick(20000, 100, 100, 100);           // e=7, 8 cycles of search
    @(negedge clk);
    req_sck_div = 24'd3; req_lead = 24'd3; req_trail = 24'd3; req_gap = 24'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk(prescale_exp == 3'd7 && sck_div == 8'd157, "R8", "busy start ignored", int'(sck_div), 157);

    run(1000, 1000, 999, 1001);           // R4 mixed
    run(300, 0, 600, 2);
    @(negedge clk);
    report();
    $finish;
  end

endmodule